// File: doc/BRIEF.md
# Overlapped Block Load Controller

This block takes a stream of 16-bit samples, which may be real or complex, and places them in a transform buffer of N points. N is a power of two between 16 and 1024. An upstream source presents one sample per strobe. The controller decides whether the strobe is accepted and then issues a registered write: address, real part and imaginary part. When the last sample a block needs has been written, it raises a one-cycle ready pulse. With that pulse it gives the buffer address of the oldest sample in the finished block.

Successive blocks can share half or three quarters of their samples with the block before. For buffer sizes below the largest, the retained samples stay where they are. A circular write base advances by the number of fresh samples, and only the vacated span is refilled. At the largest size the buffer holds no spare room, so each block is reloaded in full and the overlap setting has no effect.

Loading is gated by an enable input, which works in one of two modes:
- **Level mode:** the enable gates each strobe directly.
- **Edge mode:** a rising edge of the enable starts one complete load.

A load flag output rises when a load begins. It falls at a programmable fraction of the load. Several controllers can be chained this way, each flag driving the next enable, with the last flag fed back to the first.

Top module: `ovl_load_ctrl`

## Requirements
- R1: In level mode (`cfg_edge`=0), a strobe is written only in a cycle where `ld_en` is 1. A strobe presented while `ld_en` is 0 causes no write and does not count toward the block.
- R2: In edge mode (`cfg_edge`=1), a load starts in a cycle where `ld_en` is 1 after being 0 in the previous cycle (or after reset) and no load is running. Strobes are then accepted whatever the level of `ld_en`, until the block's fresh count is reached. A rising edge during a running load is ignored. Strobes after completion are not written until a new rising edge arrives.
- R3: The first block after reset needs N samples. Each later block needs N, N/2 or N/4 fresh samples for `cfg_ovl` codes 0, 1 and 2. Code 3 behaves like code 0.
- R4: The k-th accepted sample since reset (counting from 0) is written at address k mod N, one cycle after its strobe. `wr_re` equals the strobed real part. `wr_im` equals the strobed imaginary part when `cfg_cplx`=1 and is zero when `cfg_cplx`=0.
- R5: When the clamped size is the largest (1024 points), every block needs all 1024 samples, whatever `cfg_ovl` says.
- R6: `blk_rdy` is high for exactly one cycle, in the same cycle as the write of a block's final sample. In that cycle `rdy_base` equals the total number of accepted samples since reset, modulo N; this is the address of the block's oldest sample.
- R7: `ld_flag` is 1 in the cycle after a load starts.
- R8: `ld_flag` drops to 0 two cycles after the strobe that accepts the threshold sample, unless a new load starts in between. The threshold is F/4, F/2 or F samples of the block's fresh count F, for `cfg_flag_pt` codes 0, 1 and 2 or 3.
- R9: `cfg_log2n` gives log2 N. Values below 4 act as 4 and values above 10 act as 10.
- R10: While `rst` is high, `wr_en`, `blk_rdy` and `ld_flag` are 0. After reset, addressing restarts at 0 and the first block again needs N samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_log2n | input | 4 | log2 of the buffer size, clamped to 4..10 |
| cfg_ovl | input | 2 | Overlap code: 0 none, 1 half, 2 three quarters, 3 none |
| cfg_flag_pt | input | 2 | Load-flag drop point: 0 quarter, 1 half, 2/3 end of load |
| cfg_edge | input | 1 | 1 selects edge-started loads, 0 selects level gating |
| cfg_cplx | input | 1 | 1 keeps the imaginary part, 0 writes it as zero |
| ld_en | input | 1 | Load enable |
| smp_stb | input | 1 | Sample strobe |
| smp_re | input | 16 | Sample real part |
| smp_im | input | 16 | Sample imaginary part |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 10 | Buffer write address |
| wr_re | output | 16 | Written real part |
| wr_im | output | 16 | Written imaginary part |
| blk_rdy | output | 1 | One-cycle pulse: a block is complete |
| rdy_base | output | 10 | Oldest-sample address of the completed block |
| ld_flag | output | 1 | Load flag for the next device in a chain |

## Verification
Two situations are the hardest to reach from the ports: a second rising edge of the enable that arrives inside a running edge-mode load, and a flag threshold that is hit on the very first strobe of a load. The bench sweeps every overlap and flag-point code at 16 points. In the second block of each edge-mode run it raises the enable again on a sample strobe. It then confirms that completion still comes after exactly the fresh count and that a later strobe without a new edge writes nothing. The three-quarter overlap with the quarter flag point makes the threshold equal one sample, which exercises the short flag pulse. Long level-mode runs at 1024 points, with gaps in both strobe and enable, check that the overlap code is overridden at the largest size.

// File: rtl/olc_pkg.sv
package olc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        OVL_NONE    = 2'd0,
        OVL_HALF    = 2'd1,
        OVL_QUARTER = 2'd2,
        OVL_RSVD    = 2'd3
    } ovl_mode_e;

    typedef enum logic [1:0] {
        FPT_QUARTER = 2'd0,
        FPT_HALF    = 2'd1,
        FPT_END     = 2'd2,
        FPT_END_ALT = 2'd3
    } flag_pt_e;

    typedef enum logic {
        EN_LEVEL = 1'b0,
        EN_EDGE  = 1'b1
    } en_mode_e;

    // per-cycle load events shared by the sub-blocks
    typedef struct packed {
        logic start;
        logic accept;
        logic done;
    } ld_evt_t;

    function automatic int clamp_i(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // fresh samples required for the next block
    function automatic int fresh_of(input int n, input ovl_mode_e o,
                                    input logic primed, input logic full);
        if (!primed || full) return n;
        case (o)
            OVL_HALF:    return n >> 1;
            OVL_QUARTER: return n >> 2;
            default:     return n;
        endcase
    endfunction

    // sample count at which the load flag is released
    function automatic int thr_of(input int f, input flag_pt_e p);
        case (p)
            FPT_QUARTER: return f >> 2;
            FPT_HALF:    return f >> 1;
            default:     return f;
        endcase
    endfunction
endpackage

// File: rtl/olc_cfg_dec.sv
module olc_cfg_dec import olc_pkg::*; #(
    parameter int MAX_LOG2 = 10,
    parameter int MIN_LOG2 = 4,
    parameter int LW       = 4,
    parameter int CW       = 11,
    parameter int AW       = 10
) (
    input  logic [LW-1:0] cfg_log2n,
    input  logic [1:0]    cfg_ovl,
    input  logic [1:0]    cfg_flag_pt,
    input  logic          primed,
    output logic [CW-1:0] fresh,
    output logic [CW-1:0] thr,
    output logic [AW-1:0] amask
);
    timeunit 1ns;
    timeprecision 1ps;

    int          lg;
    logic        full;
    logic [CW-1:0] n_pts;

    always_comb begin
        lg    = clamp_i(int'(cfg_log2n), MIN_LOG2, MAX_LOG2);
        full  = (lg == MAX_LOG2);
        n_pts = CW'(1) << lg;
        amask = AW'(n_pts - CW'(1));
        fresh = CW'(fresh_of(int'(n_pts), ovl_mode_e'(cfg_ovl), primed, full));
        thr   = CW'(thr_of(int'(fresh), flag_pt_e'(cfg_flag_pt)));
    end
endmodule

// File: rtl/olc_arm.sv
module olc_arm import olc_pkg::*; #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_edge,
    input  logic          ld_en,
    input  logic          smp_stb,
    input  logic [CW-1:0] fresh,
    output ld_evt_t       evt,
    output logic [CW-1:0] cnt
);
    timeunit 1ns;
    timeprecision 1ps;

    logic          en_q;
    logic          busy;
    logic          rise;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        rise       = ld_en & ~en_q;
        evt.start  = ~busy & ((en_mode_e'(cfg_edge) == EN_EDGE) ? rise : ld_en);
        evt.accept = smp_stb & (busy | evt.start) & (cfg_edge | ld_en);
        cnt_nx     = cnt + CW'(1);
        evt.done   = evt.accept & (cnt_nx == fresh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            en_q <= ld_en;
            if (evt.done)       busy <= 1'b0;
            else if (evt.start) busy <= 1'b1;
            if (evt.done)        cnt <= '0;
            else if (evt.accept) cnt <= cnt_nx;
        end
    end

    AST_CNT_BELOW_FRESH: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < fresh)); // R3
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cnt == '0)); // R2
endmodule

// File: rtl/olc_wr.sv
module olc_wr #(
    parameter int DW = 16,
    parameter int AW = 10,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          accept,
    input  logic          done,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] fresh,
    input  logic [AW-1:0] amask,
    input  logic          cfg_cplx,
    input  logic [DW-1:0] smp_re,
    input  logic [DW-1:0] smp_im,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_re,
    output logic [DW-1:0] wr_im,
    output logic          blk_rdy,
    output logic [AW-1:0] rdy_base,
    output logic          primed
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [AW-1:0] base;
    logic [AW-1:0] base_nx;

    // circular base moves past the samples that fall out of the window
    always_comb base_nx = AW'(CW'(base) + fresh) & amask;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_re    <= '0;
            wr_im    <= '0;
            blk_rdy  <= 1'b0;
            rdy_base <= '0;
            base     <= '0;
            primed   <= 1'b0;
        end else begin
            wr_en   <= accept;
            blk_rdy <= done;
            if (accept) begin
                wr_addr <= AW'(CW'(base) + cnt) & amask;
                wr_re   <= smp_re;
                wr_im   <= cfg_cplx ? smp_im : '0;
            end
            if (done) begin
                base     <= base_nx;
                rdy_base <= base_nx;
                primed   <= 1'b1;
            end
        end
    end

    AST_ADDR_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_addr & ~amask) == '0)); // R4
    AST_REAL_IM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg_cplx) |-> (wr_im == '0)); // R4
    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        blk_rdy |=> !blk_rdy); // R6
    AST_RDY_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        blk_rdy |-> wr_en); // R6
    AST_START_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (start && !accept) |=> !wr_en); // R2
endmodule

// File: rtl/olc_flag.sv
module olc_flag #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          accept,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] thr,
    output logic          ld_flag
);
    timeunit 1ns;
    timeprecision 1ps;

    logic hit;
    logic rch;

    always_comb hit = accept & ((cnt + CW'(1)) == thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rch     <= 1'b0;
            ld_flag <= 1'b0;
        end else begin
            rch <= hit;
            if (start)    ld_flag <= 1'b1;
            else if (rch) ld_flag <= 1'b0;
        end
    end

    AST_FLAG_ON_START: assert property (@(posedge clk) disable iff (rst)
        start |=> ld_flag); // R7
    AST_FLAG_FALL: assert property (@(posedge clk) disable iff (rst)
        (rch && !start) |=> !ld_flag); // R8
endmodule

// File: rtl/ovl_load_ctrl.sv
module ovl_load_ctrl import olc_pkg::*; #(
    parameter int DW       = 16,
    parameter int MAX_LOG2 = 10,
    parameter int MIN_LOG2 = 4,
    localparam int AW      = MAX_LOG2,
    localparam int CW      = MAX_LOG2 + 1,
    localparam int LW      = $clog2(MAX_LOG2 + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] cfg_log2n,
    input  logic [1:0]    cfg_ovl,
    input  logic [1:0]    cfg_flag_pt,
    input  logic          cfg_edge,
    input  logic          cfg_cplx,
    input  logic          ld_en,
    input  logic          smp_stb,
    input  logic [DW-1:0] smp_re,
    input  logic [DW-1:0] smp_im,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_re,
    output logic [DW-1:0] wr_im,
    output logic          blk_rdy,
    output logic [AW-1:0] rdy_base,
    output logic          ld_flag
);
    timeunit 1ns;
    timeprecision 1ps;

    ld_evt_t       evt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] fresh;
    logic [CW-1:0] thr;
    logic [AW-1:0] amask;
    logic          primed;

    olc_cfg_dec #(
        .MAX_LOG2(MAX_LOG2), .MIN_LOG2(MIN_LOG2), .LW(LW), .CW(CW), .AW(AW)
    ) cfg_i (
        .cfg_log2n  (cfg_log2n),
        .cfg_ovl    (cfg_ovl),
        .cfg_flag_pt(cfg_flag_pt),
        .primed     (primed),
        .fresh      (fresh),
        .thr        (thr),
        .amask      (amask)
    );

    olc_arm #(.CW(CW)) arm_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_edge(cfg_edge),
        .ld_en   (ld_en),
        .smp_stb (smp_stb),
        .fresh   (fresh),
        .evt     (evt),
        .cnt     (cnt)
    );

    olc_wr #(.DW(DW), .AW(AW), .CW(CW)) wr_i (
        .clk     (clk),
        .rst     (rst),
        .start   (evt.start),
        .accept  (evt.accept),
        .done    (evt.done),
        .cnt     (cnt),
        .fresh   (fresh),
        .amask   (amask),
        .cfg_cplx(cfg_cplx),
        .smp_re  (smp_re),
        .smp_im  (smp_im),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_re   (wr_re),
        .wr_im   (wr_im),
        .blk_rdy (blk_rdy),
        .rdy_base(rdy_base),
        .primed  (primed)
    );

    olc_flag #(.CW(CW)) flag_i (
        .clk    (clk),
        .rst    (rst),
        .start  (evt.start),
        .accept (evt.accept),
        .cnt    (cnt),
        .thr    (thr),
        .ld_flag(ld_flag)
    );
endmodule

// File: tb/ovl_load_ctrl_tb_top.sv
module ovl_load_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_log2n = 4'd4;
    logic [1:0]  cfg_ovl = 2'd0;
    logic [1:0]  cfg_flag_pt = 2'd0;
    logic        cfg_edge = 1'b0;
    logic        cfg_cplx = 1'b0;
    logic        ld_en = 1'b0;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_re = '0;
    logic [15:0] smp_im = '0;
    logic        wr_en;
    logic [9:0]  wr_addr;
    logic [15:0] wr_re;
    logic [15:0] wr_im;
    logic        blk_rdy;
    logic [9:0]  rdy_base;
    logic        ld_flag;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int n_cur, ovl_cur, fpt_cur;
    bit cplx_cur, full_cur;
    int tot, blk, jb, rdy_seen;

    always #5 clk = ~clk;   // 10 ns period

    ovl_load_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_log2n(cfg_log2n), .cfg_ovl(cfg_ovl),
        .cfg_flag_pt(cfg_flag_pt), .cfg_edge(cfg_edge), .cfg_cplx(cfg_cplx),
        .ld_en(ld_en), .smp_stb(smp_stb), .smp_re(smp_re), .smp_im(smp_im),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im),
        .blk_rdy(blk_rdy), .rdy_base(rdy_base), .ld_flag(ld_flag)
    );

    task automatic chk(input string tg, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tg, act, exp, $time);
        end
    endtask

    function automatic int fr_blk(input int b);
        if (b == 0 || full_cur) return n_cur;
        case (ovl_cur)
            1: return n_cur / 2;
            2: return n_cur / 4;
            default: return n_cur;
        endcase
    endfunction

    function automatic int thr_calc(input int f);
        case (fpt_cur)
            0: return f / 4;
            1: return f / 2;
            default: return f;
        endcase
    endfunction

    task automatic step(input bit stb, input bit en, input logic [15:0] re, input logic [15:0] im);
        @(negedge clk);
        smp_stb = stb;
        ld_en   = en;
        smp_re  = re;
        smp_im  = im;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_sample(input bit wr, input logic [15:0] re,
                                 input logic [15:0] im, input string tg_idle);
        int f;
        f = fr_blk(blk);
        if (wr) begin
            chk("R4 wr_en", int'(wr_en), 1);
            chk("R4 wr_addr", int'(wr_addr), tot % n_cur);
            chk("R4 wr_re", int'(wr_re), int'(re));
            chk("R4 wr_im", int'(wr_im), cplx_cur ? int'(im) : 0);
            chk("R3 blk_rdy at fresh count", int'(blk_rdy), (jb == f - 1) ? 1 : 0);
            if (blk_rdy) rdy_seen++;
            if (jb == f - 1) chk("R6 rdy_base", int'(rdy_base), (tot + 1) % n_cur);
            tot++;
            jb++;
            if (jb == f) begin
                jb = 0;
                blk++;
            end
        end else begin
            chk(tg_idle, int'(wr_en), 0);
            chk("R6 no rdy without write", int'(blk_rdy), 0);
        end
    endtask

    task automatic do_reset(input int lg, input int n_eff, input int ovl, input int fpt,
                            input bit edge_m, input bit cplx);
        @(negedge clk);
        rst = 1'b1;
        ld_en = 1'b0;
        smp_stb = 1'b0;
        cfg_log2n = 4'(lg);
        cfg_ovl = 2'(ovl);
        cfg_flag_pt = 2'(fpt);
        cfg_edge = edge_m;
        cfg_cplx = cplx;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R10 reset wr_en", int'(wr_en), 0);
        chk("R10 reset ld_flag", int'(ld_flag), 0);
        chk("R10 reset blk_rdy", int'(blk_rdy), 0);
        @(negedge clk);
        rst = 1'b0;
        n_cur = n_eff;
        ovl_cur = ovl;
        fpt_cur = fpt;
        cplx_cur = cplx;
        full_cur = (n_eff == 1024);
        tot = 0;
        blk = 0;
        jb = 0;
        rdy_seen = 0;
    endtask

    task automatic run_level(input int lg, input int n_eff, input int ovl, input int fpt,
                             input bit cplx, input int nsteps, input string tg);
        int exp_blk;
        do_reset(lg, n_eff, ovl, fpt, 1'b0, cplx);
        step(1'b0, 1'b1, 16'h0, 16'h0);
        chk("R7 flag after level start", int'(ld_flag), 1);
        expect_sample(1'b0, 16'h0, 16'h0, "R1 no strobe");
        for (int i = 0; i < nsteps; i++) begin
            bit stb, en, w;
            logic [15:0] re, im;
            stb = (i % 4) != 3;
            en  = (i % 7) != 6;
            w   = stb && en;
            re  = 16'(i * 37 + 16'h0123);
            im  = 16'(16'hA5A5 ^ (i * 11));
            step(stb, en, re, im);
            expect_sample(w, re, im, "R1 strobe ignored while enable low");
        end
        if (full_cur) exp_blk = tot / n_cur;
        else if (tot < n_cur) exp_blk = 0;
        else exp_blk = 1 + (tot - n_cur) / fr_blk(1);
        chk(tg, rdy_seen, exp_blk);
    endtask

    task automatic run_edge(input int lg, input int n_eff, input int ovl, input int fpt,
                            input bit cplx, input int nblk, input string tg);
        do_reset(lg, n_eff, ovl, fpt, 1'b1, cplx);
        for (int b = 0; b < nblk; b++) begin
            int f, th;
            f  = fr_blk(blk);
            th = thr_calc(f);
            step(1'b0, 1'b1, 16'h0, 16'h0);
            chk("R7 flag after edge start", int'(ld_flag), 1);
            expect_sample(1'b0, 16'h0, 16'h0, "R2 no strobe on edge");
            for (int j = 0; j < f; j++) begin
                bit en;
                logic [15:0] re, im;
                en = (b == 1 && j == 1);
                re = 16'(tot * 5 + 16'h0400);
                im = 16'(16'h7000 + j);
                step(1'b1, en, re, im);
                expect_sample(1'b1, re, im, "R2 unused");
                if (j == th - 1) chk("R8 flag still high at threshold strobe", int'(ld_flag), 1);
                if (j == th && th < f) chk("R8 flag low after threshold", int'(ld_flag), 0);
            end
            step(1'b1, 1'b0, 16'hFFFF, 16'hFFFF);
            chk("R2 no write without new edge", int'(wr_en), 0);
            if (th == f) chk("R8 flag low after end of load", int'(ld_flag), 0);
        end
        chk(tg, rdy_seen, nblk);
    endtask

    initial begin
        for (int o = 0; o < 4; o++) begin
            for (int p = 0; p < 4; p++) begin
                run_edge(4, 16, o, p, bit'((o + p) % 2), 4, "R3 edge sweep blocks");
                run_level(4, 16, o, p, bit'(o % 2), 130, "R3 level sweep blocks");
            end
        end
        run_level(5, 32, 2, 1, 1'b1, 200, "R3 n32 blocks");
        run_level(0, 16, 1, 0, 1'b1, 100, "R9 clamp low blocks");
        run_edge(15, 1024, 2, 0, 1'b1, 1, "R9 clamp high blocks");
        run_level(10, 1024, 1, 1, 1'b0, 3000, "R5 full level blocks");
        run_edge(10, 1024, 2, 1, 1'b1, 2, "R5 full edge blocks");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule